// File: doc/BRIEF.md
# Configuration-Port Key Isolation Sequencer

This block is the device-side front end of a plug-in adapter that is found and set up through a single shared configuration port. The host writes bytes to that port and reads single bits back. The adapter ignores every command until the host has sent a two-byte zero preamble and then the full 255-byte key. The key comes from an 8-bit shift-and-XOR generator, so the block regenerates each expected byte on the fly and does not store the key.

Once the key has matched, the adapter is in command state. In that state the host can read 16-bit words from a small configuration ROM one bit per read, reset all adapters, set or clear a tag that keeps the adapter out of later sessions, or activate the adapter. Activation turns on the adapter's own I/O window. The window's base address is derived from an address-configuration word held in the ROM. The ROM image is a parameter.

Top module: `cfgkey_isolator`

## Requirements
- R1: After reset, rd_bit is 0, io_enable is 0 and io_base is 0.
- R2: Two back-to-back writes of 0x00 restart key matching at its first byte, from any state. Key bytes sent without that preamble are not accepted.
- R3: The key is 255 bytes long. Byte 0 is 0xFF, and each later byte is the previous one shifted left by one bit, XORed with 0xCF when the bit shifted out was 1. Once all 255 bytes have matched, the adapter is in command state.
- R4: Any write during key matching that differs from the expected byte sends the matcher back to waiting for the preamble. Commands written after that are ignored.
- R5: In command state, a write whose two top bits are 2'b10 selects the ROM word at offset wr_data[5:0]. The next 16 read strobes return that word most significant bit first. Each bit appears on rd_bit at the clock edge that samples the read strobe and holds until the next read.
- R6: A read strobe while no word is being shifted out, including the 17th read after a word select, returns 0.
- R7: ROM offset 7 holds the identifier word 0x6D50 and offset 8 holds the address-configuration word. Both are read through the same serial path.
- R8: In command state, a write of 0xFF sets io_enable. It also sets io_base to 0x200 + 16 × (bits [4:0] of ROM word 8), and the adapter leaves command state. Both outputs change at the edge that samples the write.
- R9: In command state, a write of 0xD1 tags the adapter. When a tagged adapter later matches the key, it enters a restricted command state in which word selects and 0xFF have no effect. Only 0xC0 and 0xD0 are still obeyed there.
- R10: A write of 0xD0 in either command state clears the tag. The next full key match then gives the unrestricted command state.
- R11: A write of 0xC0 in either command state clears io_enable, io_base, the tag and any word being shifted out, and returns the adapter to waiting for the preamble.
- R12: In command state, writes of any other code (not 0x00, not 2'b10xxxxxx, not 0xC0, 0xD0, 0xD1 or 0xFF) have no effect. A word select after them still works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Host write to the configuration port, one cycle per byte |
| wr_data | input | 8 | Byte written by the host |
| rd_stb | input | 1 | Host read of the configuration port, one cycle per bit |
| rd_bit | output | 1 | Bit returned for the most recent read |
| io_enable | output | 1 | Adapter's I/O window is active |
| io_base | output | 10 | Base address of the adapter's I/O window |

## Verification
Assertions check on every cycle that the key index stays inside the key and that the serial bit counter never exceeds one word. They also check that a read with no word pending returns 0 and that io_enable rises only after 0xFF and falls only after 0xC0. A further assertion checks that the restricted command state is entered only by a tagged adapter. The order of the key bytes, the bit order of ROM words, the effect of a wrong byte at a random key position, and tag and untag across several sessions can only be shown by the bench's write and read sequences. The same holds for the computed base address.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int OFF_W   = 6;
  localparam int WORDS   = 1 << OFF_W;

  typedef logic [WORDS-1:0][WORD_W-1:0] rom_image_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_KEY  = 2'd1,
    ST_CMD  = 2'd2,
    ST_LTD  = 2'd3
  } iso_state_t;

  localparam logic [1:0]        OP_SELECT_TOP = 2'b10;
  localparam logic [BYTE_W-1:0] OP_RESET      = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_UNTAG      = 8'hD0;
  localparam logic [BYTE_W-1:0] OP_TAG        = 8'hD1;
  localparam logic [BYTE_W-1:0] OP_ACTIVATE   = 8'hFF;

  function automatic rom_image_t default_image();
    rom_image_t img;
    for (int i = 0; i < WORDS; i++) begin
      img[i] = WORD_W'(i * 16'h0101) ^ 16'hA5C3;
    end
    img[7] = 16'h6D50;
    img[8] = 16'h0007;
    return img;
  endfunction
endpackage

// File: rtl/cfgkey_keymatch.sv
module cfgkey_keymatch
  import cfgkey_pkg::*;
#(
  parameter int               KEY_LEN = 255,
  parameter logic [BYTE_W-1:0] SEED   = 8'hFF,
  parameter logic [BYTE_W-1:0] TAPS   = 8'hCF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  output logic [BYTE_W-1:0] expect_byte,
  output logic              at_last
);
  localparam int IDX_W = $clog2(KEY_LEN);

  logic [BYTE_W-1:0] exp_q, exp_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [BYTE_W-1:0] stepped;

  always_comb begin
    stepped = {exp_q[BYTE_W-2:0], 1'b0} ^ (exp_q[BYTE_W-1] ? TAPS : '0);
  end

  assign at_last     = (idx_q == IDX_W'(KEY_LEN - 1));
  assign expect_byte = exp_q;

  always_comb begin
    exp_n = exp_q;
    idx_n = idx_q;
    if (restart) begin
      exp_n = SEED;
      idx_n = '0;
    end else if (advance) begin
      exp_n = stepped;
      idx_n = at_last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= SEED;
      idx_q <= '0;
    end else if (restart || advance) begin
      exp_q <= exp_n;
      idx_q <= idx_n;
    end
  end

  p_key_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(KEY_LEN))
    else $error("key index left the key");
endmodule

// File: rtl/cfgkey_romshift.sv
module cfgkey_romshift
  import cfgkey_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              clear,
  input  logic              rd_stb,
  output logic              rd_bit
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              bit_q, bit_n;
  logic              pending;

  assign pending = (cnt_q != '0);

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    bit_n = bit_q;
    if (rd_stb) begin
      bit_n = pending ? sh_q[WORD_W-1] : 1'b0;
      if (pending) begin
        sh_n  = {sh_q[WORD_W-2:0], 1'b0};
        cnt_n = cnt_q - 1'b1;
      end
    end
    if (clear) begin
      cnt_n = '0;
    end else if (load) begin
      sh_n  = word;
      cnt_n = CNT_W'(WORD_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      bit_q <= 1'b0;
    end else if (rd_stb || load || clear) begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      bit_q <= bit_n;
    end
  end

  assign rd_bit = bit_q;

  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(WORD_W))
    else $error("bit counter above word width");

  p_idle_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !pending) |=> !rd_bit)
    else $error("read with nothing pending returned 1");
endmodule

// File: rtl/cfgkey_ctrl.sv
module cfgkey_ctrl
  import cfgkey_pkg::*;
#(
  parameter int               ADDR_W      = 10,
  parameter logic [ADDR_W-1:0] BASE_ORIGIN = 10'h200,
  parameter int               BASE_SHIFT  = 4,
  parameter int               FIELD_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] expect_byte,
  input  logic              key_last,
  input  logic [WORD_W-1:0] cfg_word,
  output logic              key_restart,
  output logic              key_advance,
  output logic              rom_load,
  output logic [OFF_W-1:0]  rom_off,
  output logic              rom_clear,
  output logic              io_enable,
  output logic [ADDR_W-1:0] io_base
);
  iso_state_t        state_q, state_n;
  logic              zero_q, zero_n;
  logic              tag_q, tag_n;
  logic              act_q, act_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic              is_zero;
  logic [ADDR_W-1:0] computed_base;

  assign is_zero       = (wr_data == '0);
  assign computed_base = BASE_ORIGIN +
                         (ADDR_W'(cfg_word[FIELD_W-1:0]) << BASE_SHIFT);
  assign rom_off       = wr_data[OFF_W-1:0];

  always_comb begin
    state_n     = state_q;
    zero_n      = zero_q;
    tag_n       = tag_q;
    act_n       = act_q;
    base_n      = base_q;
    key_restart = 1'b0;
    key_advance = 1'b0;
    rom_load    = 1'b0;
    rom_clear   = 1'b0;
    if (wr_stb) begin
      zero_n = is_zero;
      if (is_zero && zero_q) begin
        state_n     = ST_KEY;
        key_restart = 1'b1;
      end else begin
        unique case (state_q)
          ST_KEY: begin
            if (wr_data == expect_byte) begin
              key_advance = 1'b1;
              if (key_last) state_n = tag_q ? ST_LTD : ST_CMD;
            end else begin
              state_n = ST_IDLE;
            end
          end
          ST_CMD, ST_LTD: begin
            if (wr_data == OP_RESET) begin
              state_n   = ST_IDLE;
              tag_n     = 1'b0;
              act_n     = 1'b0;
              base_n    = '0;
              rom_clear = 1'b1;
            end else if (wr_data == OP_UNTAG) begin
              tag_n = 1'b0;
            end else if (state_q == ST_CMD) begin
              if (wr_data[BYTE_W-1 -: 2] == OP_SELECT_TOP) begin
                rom_load = 1'b1;
              end else if (wr_data == OP_TAG) begin
                tag_n = 1'b1;
              end else if (wr_data == OP_ACTIVATE) begin
                act_n   = 1'b1;
                base_n  = computed_base;
                state_n = ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      zero_q  <= 1'b0;
      tag_q   <= 1'b0;
      act_q   <= 1'b0;
      base_q  <= '0;
    end else if (wr_stb) begin
      state_q <= state_n;
      zero_q  <= zero_n;
      tag_q   <= tag_n;
      act_q   <= act_n;
      base_q  <= base_n;
    end
  end

  assign io_enable = act_q;
  assign io_base   = base_q;

  p_activate_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_enable) |-> $past(wr_stb && wr_data == OP_ACTIVATE))
    else $error("window enabled without activate write");

  p_reset_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_enable) |-> $past(wr_stb && wr_data == OP_RESET))
    else $error("window disabled without reset write");

  p_restricted_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LTD && $past(state_q) != ST_LTD) |-> $past(tag_q))
    else $error("restricted state entered while untagged");
endmodule

// File: rtl/cfgkey_isolator.sv
module cfgkey_isolator
  import cfgkey_pkg::*;
#(
  parameter int               KEY_LEN     = 255,
  parameter logic [BYTE_W-1:0] KEY_SEED   = 8'hFF,
  parameter logic [BYTE_W-1:0] KEY_TAPS   = 8'hCF,
  parameter int               CFG_OFF     = 8,
  parameter int               ADDR_W      = 10,
  parameter logic [ADDR_W-1:0] BASE_ORIGIN = 10'h200,
  parameter int               BASE_SHIFT  = 4,
  parameter int               FIELD_W     = 5,
  parameter rom_image_t       ROM_IMAGE   = default_image()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic              rd_bit,
  output logic              io_enable,
  output logic [ADDR_W-1:0] io_base
);
  logic [BYTE_W-1:0] expect_byte;
  logic              key_last, key_restart, key_advance;
  logic              rom_load, rom_clear;
  logic [OFF_W-1:0]  rom_off;
  logic [WORD_W-1:0] sel_word;
  logic [WORD_W-1:0] cfg_word;

  assign sel_word = ROM_IMAGE[rom_off];
  assign cfg_word = ROM_IMAGE[CFG_OFF];

  cfgkey_keymatch #(
    .KEY_LEN (KEY_LEN),
    .SEED    (KEY_SEED),
    .TAPS    (KEY_TAPS)
  ) u_key (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (key_restart),
    .advance     (key_advance),
    .expect_byte (expect_byte),
    .at_last     (key_last)
  );

  cfgkey_ctrl #(
    .ADDR_W      (ADDR_W),
    .BASE_ORIGIN (BASE_ORIGIN),
    .BASE_SHIFT  (BASE_SHIFT),
    .FIELD_W     (FIELD_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stb      (wr_stb),
    .wr_data     (wr_data),
    .expect_byte (expect_byte),
    .key_last    (key_last),
    .cfg_word    (cfg_word),
    .key_restart (key_restart),
    .key_advance (key_advance),
    .rom_load    (rom_load),
    .rom_off     (rom_off),
    .rom_clear   (rom_clear),
    .io_enable   (io_enable),
    .io_base     (io_base)
  );

  cfgkey_romshift u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (rom_load),
    .word   (sel_word),
    .clear  (rom_clear),
    .rd_stb (rd_stb),
    .rd_bit (rd_bit)
  );
endmodule

// File: tb/cfgkey_isolator_tb_top.sv
module cfgkey_isolator_tb_top;
  import cfgkey_pkg::*;

  localparam int CLK_PERIOD = 10;

  function automatic rom_image_t bench_image();
    rom_image_t img;
    for (int i = 0; i < WORDS; i++) begin
      img[i] = 16'((i * 16'h9E37) ^ 16'h5A5A);
    end
    img[7] = 16'h6D50;
    img[8] = 16'h3ABC;
    return img;
  endfunction

  localparam rom_image_t IMG = bench_image();

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_stb = 1'b0;
  logic       rd_bit;
  logic       io_enable;
  logic [9:0] io_base;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgkey_isolator #(.ROM_IMAGE(IMG)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .rd_stb    (rd_stb),
    .rd_bit    (rd_bit),
    .io_enable (io_enable),
    .io_base   (io_base)
  );

  function automatic logic [7:0] key_step(logic [7:0] x);
    logic [7:0] y;
    y = x << 1;
    if (x[7]) y = y ^ 8'hCF;
    return y;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_stb  = 1'b0;
  endtask

  task automatic rd(output logic b);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    b = rd_bit;
  endtask

  task automatic read16(output logic [15:0] w);
    logic b;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      rd(b);
      w = {w[14:0], b};
    end
  endtask

  task automatic preamble();
    wr(8'h00);
    wr(8'h00);
  endtask

  // sends key bytes; a byte at index bad_at (if < 255) is corrupted
  task automatic send_key(int bad_at);
    logic [7:0] k;
    k = 8'hFF;
    for (int i = 0; i < 255; i++) begin
      if (i == bad_at) begin
        wr(k ^ 8'h01);
        return;
      end
      wr(k);
      k = key_step(k);
    end
  endtask

  task automatic unlock();
    preamble();
    send_key(255);
  endtask

  task automatic fetch(int off, output logic [15:0] w);
    wr(8'h80 | 8'(off));
    read16(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    logic        b;
    logic [7:0]  junk;
    int          off, pos;
    void'($urandom(32'd4711));

    repeat (3) @(negedge clk);
    // R1: reset state
    check(rd_bit == 1'b0, "R1 rd_bit", 32'(rd_bit), 0);
    check(io_enable == 1'b0, "R1 io_enable", 32'(io_enable), 0);
    check(io_base == 10'h0, "R1 io_base", 32'(io_base), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: key without preamble is not accepted
    send_key(255);
    fetch(7, w);
    check(w == 16'h0, "R2 key without preamble", 32'(w), 0);

    // R3/R7: full key unlocks, identifier word reads back
    unlock();
    fetch(7, w);
    check(w == 16'h6D50, "R7 identifier word", 32'(w), 32'h6D50);
    // R6: 17th read returns zero
    rd(b);
    check(b == 1'b0, "R6 read past word end", 32'(b), 0);
    rd(b);
    check(b == 1'b0, "R6 idle read", 32'(b), 0);
    fetch(8, w);
    check(w == IMG[8], "R7 address config word", 32'(w), 32'(IMG[8]));

    // R5: random offsets, MSB-first
    for (int n = 0; n < 12; n++) begin
      off = int'($urandom_range(63));
      fetch(off, w);
      check(w == IMG[off], "R5 word readout", 32'(w), 32'(IMG[off]));
    end
    // R5: a single bit holds between reads
    wr(8'h87);
    rd(b);
    repeat (3) @(negedge clk);
    check(b == rd_bit && rd_bit == 1'b0, "R5 bit holds", 32'(rd_bit), 0);

    // R12: ignored codes in command state
    for (int n = 0; n < 8; n++) begin
      do junk = 8'($urandom_range(255));
      while (junk == 8'h00 || junk[7:6] == 2'b10 || junk == 8'hC0 ||
             junk == 8'hD0 || junk == 8'hD1 || junk == 8'hFF);
      wr(junk);
      check(io_enable == 1'b0, "R12 junk leaves window off", 32'(io_enable), 0);
    end
    fetch(7, w);
    check(w == 16'h6D50, "R12 select still works", 32'(w), 32'h6D50);

    // R4: wrong byte at random key positions
    for (int n = 0; n < 6; n++) begin
      pos = int'($urandom_range(254));
      preamble();
      send_key(pos);
      fetch(7, w);
      check(w == 16'h0, "R4 wrong key byte", 32'(w), 0);
    end
    // R4 corner: wrong final byte, then remaining bytes do nothing
    preamble();
    send_key(254);
    wr(8'hFF);
    check(io_enable == 1'b0, "R4 activate after bad key", 32'(io_enable), 0);

    // R2: preamble mid-key restarts matching
    preamble();
    send_key(100);
    preamble();
    send_key(255);
    fetch(7, w);
    check(w == 16'h6D50, "R2 restart mid key", 32'(w), 32'h6D50);

    // R9: tag, session still full; next session restricted
    wr(8'hD1);
    fetch(7, w);
    check(w == 16'h6D50, "R9 tag keeps current session", 32'(w), 32'h6D50);
    unlock();
    fetch(7, w);
    check(w == 16'h0, "R9 tagged select ignored", 32'(w), 0);
    wr(8'hFF);
    check(io_enable == 1'b0, "R9 tagged activate ignored", 32'(io_enable), 0);

    // R10: untag in restricted state, next key gives full state
    wr(8'hD0);
    unlock();
    fetch(7, w);
    check(w == 16'h6D50, "R10 untag restores access", 32'(w), 32'h6D50);

    // R8: activate
    wr(8'hFF);
    check(io_enable == 1'b1, "R8 io_enable", 32'(io_enable), 1);
    check(io_base == 10'h200 + (10'(IMG[8][4:0]) << 4), "R8 io_base",
          32'(io_base), 32'(10'h200 + (10'(IMG[8][4:0]) << 4)));
    fetch(7, w);
    check(w == 16'h0, "R8 command state left", 32'(w), 0);

    // R11: reset command clears window and pending stream
    unlock();
    wr(8'h87);
    rd(b); rd(b); rd(b);
    wr(8'hC0);
    check(io_enable == 1'b0, "R11 io_enable cleared", 32'(io_enable), 0);
    check(io_base == 10'h0, "R11 io_base cleared", 32'(io_base), 0);
    rd(b);
    check(b == 1'b0, "R11 stream cleared", 32'(b), 0);
    wr(8'h87);
    rd(b);
    check(b == 1'b0, "R11 command state left", 32'(b), 0);

    // R11: reset clears a tag as well
    unlock();
    wr(8'hD1);
    wr(8'hC0);
    unlock();
    fetch(7, w);
    check(w == 16'h6D50, "R11 tag cleared", 32'(w), 32'h6D50);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule